// File: doc/BRIEF.md
# Serial Character Transmitter with Flow Handshake

This block turns characters handed over by a processor into an asynchronous serial stream. A bit-rate enable that pulses at sixteen times the bit rate sets the timing. A one-character holding register sits in front of the shift engine, so the processor can queue the next character while the current one is still on the line. Word length, the parity-slot content and the stop length are set by static configuration inputs. The stop length can be set in steps of one sixteenth of a bit.

Single-cycle command pulses switch the transmitter on or off and start or end a break condition. An optional clear-to-send input holds back the start of each new character. An optional request-to-send output can be released by hardware once everything queued has drained after a disable. In multidrop operation the parity slot carries an address/data marker that is chosen with each write.

Top module: `async_tx_unit`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 0, `rts_n` is 1 and `tx_empty` is 1. Whenever no character is being shifted and no break is active, `txd` is 1.
- R2: A character is sent as one start bit (0), followed by the data bits least significant bit first, and each bit lasts 16 `tick16` pulses. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
- R3: `cfg_par` code 0 sends no parity slot. Code 1 appends a bit that makes the count of ones in data plus slot even. Code 2 appends a bit that makes that count odd.
- R4: With `cfg_par` code 3 the slot after the data bits carries the `wr_addr` value captured with that character's write: 1 marks an address, 0 marks data.
- R5: The stop interval lasts 16 + `cfg_stop_ext` ticks. Any `cfg_stop_ext` value above 16 behaves as 16, so the stop interval runs from 1 to 2 bit times in sixteenth-bit steps.
- R6: `tx_ready` equals "transmitter enabled and holding register empty". A write (`wr_valid` while `tx_ready`) drops `tx_ready` on the next cycle. Writes made while `tx_ready` is low are ignored.
- R7: If a character is held when the stop interval of the previous character ends, its start bit follows with no idle gap.
- R8: `cmd_disable` clears `tx_ready` at once. A character already in the shifter and one in the holding register are still sent completely, after which the line rests at 1.
- R9: From the cycle after `cmd_brk_start` until `cmd_brk_stop`, `txd` is 0. Any character in progress or held is discarded, and characters written during the break are not sent. `cmd_brk_stop` wins if both commands arrive together.
- R10: With `cfg_cts_en` at 1, a new character starts only while `cts_n` is 0. A character that has already started completes even if `cts_n` rises.
- R11: `rts_assert` drives `rts_n` to 0. With `cfg_rts_auto` at 1 and the transmitter disabled, `rts_n` returns to 1 only after both the shifter and the holding register are empty. With `cfg_rts_auto` at 0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| cfg_len | input | 2 | Data bit count code (5 + code) |
| cfg_par | input | 2 | Parity slot mode: none, even, odd, address flag |
| cfg_stop_ext | input | 5 | Extra stop ticks beyond 16, clamped to 16 |
| cfg_cts_en | input | 1 | Gate character starts on clear-to-send |
| cfg_rts_auto | input | 1 | Release request-to-send after drain when disabled |
| cts_n | input | 1 | Clear-to-send, active low |
| cmd_enable | input | 1 | Enable transmitter (pulse) |
| cmd_disable | input | 1 | Disable transmitter (pulse, wins over enable) |
| cmd_brk_start | input | 1 | Begin break (pulse) |
| cmd_brk_stop | input | 1 | End break (pulse) |
| rts_assert | input | 1 | Assert request-to-send (pulse) |
| wr_valid | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| wr_addr | input | 1 | Multidrop address marker for this character |
| txd | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Shifter and holding register both empty |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Assertions check on every cycle that the line rests at mark whenever the shifter is idle outside a break. They also check that the line is at space right after a break command, that a write always empties `tx_ready`, that no character begins while clear-to-send gates it off, that request-to-send rises only once everything has drained, and that the stop counter stays inside its programmed length. Only the bench scenarios can show the serial content itself: bit order, parity values for every length and mode, the exact stop duration for each extension value, back-to-back spacing, the draining after a disable, and the loss of characters around a break.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ADDR = 2'd3
  } par_mode_e;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_START = 2'd1,
    SH_DATA  = 2'd2,
    SH_STOP  = 2'd3
  } sh_state_e;
endpackage

// File: rtl/tx_hold.sv
module tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              brk,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_addr,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              addr,
  output logic              ready
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              addr_q, addr_d;
  logic              accept;

  assign ready  = en && !full_q;
  assign accept = wr_valid && ready && !brk;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    addr_d = addr_q;
    if (flush) begin
      full_d = 1'b0;
    end else if (take) begin
      full_d = 1'b0;
    end else if (accept) begin
      full_d = 1'b1;
      data_d = wr_data;
      addr_d = wr_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      addr_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (accept) begin
        data_q <= data_d;
        addr_q <= addr_d;
      end
    end
  end

  assign full = full_q;
  assign data = data_q;
  assign addr = addr_q;

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ready && !brk && !flush) |=> !ready);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TPB    = 16,
  parameter int EXT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              flush,
  input  logic              go,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_addr,
  input  logic [1:0]        cfg_len,
  input  par_mode_e         cfg_par,
  input  logic [EXT_W-1:0]  cfg_stop_ext,
  output logic              take,
  output logic              line,
  output logic              busy
);
  localparam int MIN_LEN = DATA_W - 3;
  localparam int IDX_W   = $clog2(DATA_W + 2);
  localparam int SL_W    = $clog2(2 * TPB + 1);

  sh_state_e         state_q, state_d;
  logic [SL_W-1:0]   tcnt_q, tcnt_d;
  logic [SL_W-1:0]   stop_len_q, stop_len_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic [IDX_W-1:0]  nbits_q, nbits_d;
  logic [DATA_W:0]   frame_q, frame_d;

  logic [DATA_W:0]   frame_n;
  logic [IDX_W-1:0]  len_sel, nbits_n;
  logic [SL_W-1:0]   stop_n;
  logic              par_acc, slot_bit;
  logic              bit_end, stop_end, start_ok;

  // frame image built from the holding register and configuration
  always_comb begin
    len_sel = IDX_W'(MIN_LEN) + IDX_W'(cfg_len);
    frame_n = '0;
    par_acc = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (IDX_W'(i) < len_sel) begin
        frame_n[i] = hold_data[i];
        par_acc    = par_acc ^ hold_data[i];
      end
    end
    case (cfg_par)
      PAR_EVEN: slot_bit = par_acc;
      PAR_ODD:  slot_bit = !par_acc;
      PAR_ADDR: slot_bit = hold_addr;
      default:  slot_bit = 1'b0;
    endcase
    frame_n[len_sel] = slot_bit;
    nbits_n = len_sel + ((cfg_par != PAR_NONE) ? IDX_W'(1) : IDX_W'(0));
    if (cfg_stop_ext > EXT_W'(TPB)) stop_n = SL_W'(2 * TPB);
    else                            stop_n = SL_W'(TPB) + SL_W'(cfg_stop_ext);
  end

  always_comb begin
    state_d    = state_q;
    tcnt_d     = tcnt_q;
    bidx_d     = bidx_q;
    nbits_d    = nbits_q;
    frame_d    = frame_q;
    stop_len_d = stop_len_q;
    take       = 1'b0;
    bit_end    = tick && (tcnt_q == SL_W'(TPB - 1));
    stop_end   = tick && (tcnt_q == stop_len_q - SL_W'(1));
    start_ok   = tick && hold_full && go && !flush;
    case (state_q)
      SH_IDLE: begin
        if (start_ok) take = 1'b1;
      end
      SH_START: begin
        if (bit_end) begin
          state_d = SH_DATA;
          tcnt_d  = '0;
          bidx_d  = '0;
        end else if (tick) begin
          tcnt_d = tcnt_q + SL_W'(1);
        end
      end
      SH_DATA: begin
        if (bit_end) begin
          tcnt_d = '0;
          if (bidx_q == nbits_q - IDX_W'(1)) state_d = SH_STOP;
          else                               bidx_d  = bidx_q + IDX_W'(1);
        end else if (tick) begin
          tcnt_d = tcnt_q + SL_W'(1);
        end
      end
      default: begin
        if (stop_end) begin
          tcnt_d = '0;
          if (start_ok) take    = 1'b1;
          else          state_d = SH_IDLE;
        end else if (tick) begin
          tcnt_d = tcnt_q + SL_W'(1);
        end
      end
    endcase
    if (take) begin
      state_d    = SH_START;
      tcnt_d     = '0;
      frame_d    = frame_n;
      nbits_d    = nbits_n;
      stop_len_d = stop_n;
    end
    if (flush) begin
      state_d = SH_IDLE;
      tcnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SH_IDLE;
      tcnt_q     <= '0;
      bidx_q     <= '0;
      nbits_q    <= '0;
      frame_q    <= '0;
      stop_len_q <= SL_W'(TPB);
    end else begin
      state_q    <= state_d;
      tcnt_q     <= tcnt_d;
      bidx_q     <= bidx_d;
      nbits_q    <= nbits_d;
      frame_q    <= frame_d;
      stop_len_q <= stop_len_d;
    end
  end

  always_comb begin
    case (state_q)
      SH_START: line = 1'b0;
      SH_DATA:  line = frame_q[bidx_q];
      default:  line = 1'b1;
    endcase
  end

  assign busy = (state_q != SH_IDLE);

  // R5
  stop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_STOP) |-> (tcnt_q < stop_len_q));

  // R5
  stop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stop_len_q >= SL_W'(TPB)) && (stop_len_q <= SL_W'(2 * TPB)));
endmodule

// File: rtl/tx_rts_ctl.sv
module tx_rts_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_assert,
  input  logic auto_en,
  input  logic en,
  input  logic drained,
  output logic rts_n
);
  logic rts_q, rts_d;

  always_comb begin
    rts_d = rts_q;
    if (rts_assert)                    rts_d = 1'b1;
    else if (auto_en && !en && drained) rts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b0;
    else        rts_q <= rts_d;
  end

  assign rts_n = !rts_q;
endmodule

// File: rtl/async_tx_unit.sv
module async_tx_unit
  import tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TPB    = 16,
  parameter int EXT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic [EXT_W-1:0]  cfg_stop_ext,
  input  logic              cfg_cts_en,
  input  logic              cfg_rts_auto,
  input  logic              cts_n,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_brk_start,
  input  logic              cmd_brk_stop,
  input  logic              rts_assert,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_addr,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty,
  output logic              rts_n
);
  logic en_q, en_d;
  logic brk_q, brk_d;
  logic flush, go;
  logic hold_full, hold_addr, take;
  logic [DATA_W-1:0] hold_data;
  logic line, busy;

  always_comb begin
    en_d = en_q;
    if (cmd_disable)     en_d = 1'b0;
    else if (cmd_enable) en_d = 1'b1;
    brk_d = brk_q;
    if (cmd_brk_stop)       brk_d = 1'b0;
    else if (cmd_brk_start) brk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      brk_q <= brk_d;
    end
  end

  assign flush = cmd_brk_start && !cmd_brk_stop;
  assign go    = !brk_q && (!cfg_cts_en || !cts_n);

  tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .brk      (brk_q),
    .flush    (flush),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_addr  (wr_addr),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data),
    .addr     (hold_addr),
    .ready    (tx_ready)
  );

  tx_shifter #(.DATA_W(DATA_W), .TPB(TPB), .EXT_W(EXT_W)) i_shifter (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick16),
    .flush        (flush),
    .go           (go),
    .hold_full    (hold_full),
    .hold_data    (hold_data),
    .hold_addr    (hold_addr),
    .cfg_len      (cfg_len),
    .cfg_par      (par_mode_e'(cfg_par)),
    .cfg_stop_ext (cfg_stop_ext),
    .take         (take),
    .line         (line),
    .busy         (busy)
  );

  tx_rts_ctl i_rts (
    .clk        (clk),
    .rst_n      (rst_n),
    .rts_assert (rts_assert),
    .auto_en    (cfg_rts_auto),
    .en         (en_q),
    .drained    (!busy && !hold_full),
    .rts_n      (rts_n)
  );

  assign txd      = brk_q ? 1'b0 : line;
  assign tx_empty = !busy && !hold_full;

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk_q) |-> txd);

  // R9
  brk_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_brk_start && !cmd_brk_stop) |=> !txd);

  // R10
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cfg_cts_en && cts_n));

  // R11
  rts_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> (!busy && !hold_full));
endmodule

// File: tb/test_async_tx_unit.sv
module test_async_tx_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_par = 2'd0;
  logic [4:0] cfg_stop_ext = 5'd0;
  logic cfg_cts_en = 1'b0, cfg_rts_auto = 1'b0, cts_n = 1'b1;
  logic cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_brk_start = 1'b0, cmd_brk_stop = 1'b0;
  logic rts_assert = 1'b0, wr_valid = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, tx_ready, tx_empty, rts_n;

  int errors = 0, checks = 0, tp = 1, tc = 0;

  async_tx_unit i_async_tx_unit (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop_ext(cfg_stop_ext), .cfg_cts_en(cfg_cts_en), .cfg_rts_auto(cfg_rts_auto),
    .cts_n(cts_n), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop), .rts_assert(rts_assert),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_addr(wr_addr),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .rts_n(rts_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (tc >= tp - 1) begin tick16 = 1'b1; tc = 0; end
      else begin tick16 = 1'b0; tc++; end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: act=running exp=finished");
    report();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic a);
    int n = 0;
    while (!tx_ready && n < 5000) begin @(negedge clk); n++; end
    wr_data = d; wr_addr = a; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic wr_force(input logic [7:0] d);
    @(negedge clk); wr_data = d; wr_addr = 1'b0; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  function automatic logic [9:0] exp_frame(input logic [7:0] d, input int len, input int par, input logic a);
    logic [9:0] f = '0; logic p = 1'b0;
    for (int i = 0; i < len; i++) begin f[i] = d[i]; p ^= d[i]; end
    case (par)
      1: f[len] = p;
      2: f[len] = ~p;
      3: f[len] = a;
      default: f[len] = 1'b0;
    endcase
    return f;
  endfunction

  // waits for a start bit at a falling clock edge, samples each bit centre, then counts mark cycles
  task automatic grab(input int nb, input int lim, output logic [9:0] got, output int stopc, output bit seen);
    int n = 0;
    got = '0; stopc = 0; seen = 1'b0;
    while (txd !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
    if (txd !== 1'b0) return;
    seen = 1'b1;
    repeat (8 * tp) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (16 * tp) @(negedge clk);
      got[i] = txd;
    end
    repeat (8 * tp) @(negedge clk);
    while (txd === 1'b1 && stopc < lim) begin stopc++; @(negedge clk); end
  endtask

  task automatic idle_for(input int n, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (txd !== 1'b1) ok = 1'b0; end
    chk(ok, tag, {31'd0, ok}, 32'd1);
  endtask

  initial begin
    logic [9:0] ga, gb;
    int sa, sb;
    bit va, vb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(tx_ready === 1'b0, "R1 tx_ready", tx_ready, 0);
    chk(rts_n === 1'b1, "R1 rts_n", rts_n, 1);
    chk(tx_empty === 1'b1, "R1 tx_empty", tx_empty, 1);

    // R6 writes while disabled are ignored
    wr_force(8'h5A);
    pulse(cmd_enable);
    chk(tx_ready === 1'b1, "R6 ready after enable", tx_ready, 1);
    idle_for(60, "R6 disabled write ignored");
    chk(tx_empty === 1'b1, "R6 empty after ignored write", tx_empty, 1);

    // R2 R3 R4 R7: sweep length and parity modes, back-to-back pairs
    for (int ln = 0; ln < 4; ln++) begin
      for (int pm = 0; pm < 4; pm++) begin
        logic [7:0] da, db;
        int nb;
        da = 8'hA5 ^ 8'(ln * 37 + pm * 11);
        db = ~da ^ 8'(pm);
        cfg_len = 2'(ln); cfg_par = 2'(pm); cfg_stop_ext = 5'd0;
        nb = 5 + ln + ((pm != 0) ? 1 : 0);
        fork
          begin wr(da, 1'b1); wr(db, 1'b0); end
          begin grab(nb, 40, ga, sa, va); grab(nb, 40, gb, sb, vb); end
        join
        chk(va && ga == exp_frame(da, 5 + ln, pm, 1'b1), (pm == 3) ? "R4 addr frame" : "R2 R3 frame A",
            {22'd0, ga}, {22'd0, exp_frame(da, 5 + ln, pm, 1'b1)});
        chk(vb && gb == exp_frame(db, 5 + ln, pm, 1'b0), (pm == 3) ? "R4 data frame" : "R2 R3 frame B",
            {22'd0, gb}, {22'd0, exp_frame(db, 5 + ln, pm, 1'b0)});
        chk(sa == 16, "R7 no gap", sa, 16);
      end
    end

    // R5 stop length sweep including clamped values
    cfg_len = 2'd3; cfg_par = 2'd0;
    for (int e = 0; e < 20; e++) begin
      int ex;
      cfg_stop_ext = 5'(e);
      ex = 16 + ((e > 16) ? 16 : e);
      fork
        begin wr(8'(e * 13), 1'b0); wr(8'hC3, 1'b0); end
        begin grab(8, 40, ga, sa, va); grab(8, 40, gb, sb, vb); end
      join
      chk(va && sa == ex, "R5 stop ticks", sa, ex);
    end

    // R2 bit duration scales with the tick rate
    tp = 3; cfg_stop_ext = 5'd4; cfg_par = 2'd1;
    fork
      begin wr(8'h96, 1'b0); wr(8'h01, 1'b0); end
      begin grab(9, 200, ga, sa, va); grab(9, 200, gb, sb, vb); end
    join
    chk(va && ga == exp_frame(8'h96, 8, 1, 1'b0), "R2 slow tick frame", {22'd0, ga}, {22'd0, exp_frame(8'h96, 8, 1, 1'b0)});
    chk(sa == 60, "R5 slow tick stop", sa, 60);
    tp = 1; cfg_par = 2'd0; cfg_stop_ext = 5'd0;
    repeat (40) @(negedge clk);

    // R10 clear-to-send gating
    cfg_cts_en = 1'b1; cts_n = 1'b1;
    wr(8'h3C, 1'b0);
    chk(tx_ready === 1'b0, "R6 ready drops after write", tx_ready, 0);
    idle_for(100, "R10 held while cts high");
    cts_n = 1'b0;
    grab(8, 40, ga, sa, va);
    chk(va && ga == exp_frame(8'h3C, 8, 0, 1'b0), "R10 frame after cts", {22'd0, ga}, {22'd0, exp_frame(8'h3C, 8, 0, 1'b0)});
    fork
      begin wr(8'hE1, 1'b0); wr(8'h7E, 1'b0); end
      begin grab(8, 40, ga, sa, va); end
      begin
        while (txd !== 1'b0) @(negedge clk);
        repeat (30) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    chk(va && ga == exp_frame(8'hE1, 8, 0, 1'b0), "R10 in-progress completes", {22'd0, ga}, {22'd0, exp_frame(8'hE1, 8, 0, 1'b0)});
    idle_for(100, "R10 next char waits");
    chk(tx_ready === 1'b0, "R10 char still held", tx_ready, 0);
    cts_n = 1'b0;
    grab(8, 40, ga, sa, va);
    chk(va && ga == exp_frame(8'h7E, 8, 0, 1'b0), "R10 held char sent", {22'd0, ga}, {22'd0, exp_frame(8'h7E, 8, 0, 1'b0)});
    cfg_cts_en = 1'b0;

    // R9 break
    pulse(cmd_brk_start);
    chk(txd === 1'b0, "R9 space after start", txd, 0);
    wr(8'h55, 1'b0);
    repeat (40) @(negedge clk);
    chk(txd === 1'b0, "R9 space held", txd, 0);
    pulse(cmd_brk_stop);
    idle_for(120, "R9 write during break dropped");
    chk(tx_empty === 1'b1, "R9 empty after break", tx_empty, 1);
    wr(8'h0F, 1'b0);
    wr(8'hF0, 1'b0);
    repeat (40) @(negedge clk);
    pulse(cmd_brk_start);
    repeat (20) @(negedge clk);
    pulse(cmd_brk_stop);
    idle_for(120, "R9 in-progress abandoned");
    chk(tx_empty === 1'b1, "R9 queue discarded", tx_empty, 1);

    // R8 R11 disable drains both registers, then request-to-send drops
    cfg_rts_auto = 1'b1;
    pulse(rts_assert);
    chk(rts_n === 1'b0, "R11 rts asserted", rts_n, 0);
    fork
      begin wr(8'h81, 1'b0); wr(8'h42, 1'b0); pulse(cmd_disable);
            chk(tx_ready === 1'b0, "R8 ready off after disable", tx_ready, 0); end
      begin grab(8, 40, ga, sa, va); grab(8, 40, gb, sb, vb); end
    join
    chk(va && ga == exp_frame(8'h81, 8, 0, 1'b0), "R8 shifter char sent", {22'd0, ga}, {22'd0, exp_frame(8'h81, 8, 0, 1'b0)});
    chk(vb && gb == exp_frame(8'h42, 8, 0, 1'b0), "R8 held char sent", {22'd0, gb}, {22'd0, exp_frame(8'h42, 8, 0, 1'b0)});
    chk(rts_n === 1'b1, "R11 rts released after drain", rts_n, 1);
    wr_force(8'h99);
    idle_for(80, "R8 write after disable ignored");
    cfg_rts_auto = 1'b0;
    pulse(rts_assert);
    repeat (50) @(negedge clk);
    chk(rts_n === 1'b0, "R11 no release when auto off", rts_n, 0);

    report();
  end
endmodule